// File: doc/BRIEF.md
# Gated 16-bit Event Counter

This block is a 16-bit up-counter that software sees as two byte registers. It can count pulses of an internal tick or rising edges on an external clock input. Either source passes through a prescaler that divides by 1, 2, 4 or 8 before it reaches the counter.

A gate input can qualify counting, with a polarity chosen by a control bit. Counting then only happens while the gate is in its active level, so the final count gives the width of a gate pulse in source periods. When the count rolls over from 0xFFFF to 0x0000, a sticky flag is set and drives the interrupt output. Software clears the flag by writing to a status register.

The register bus is byte-wide and has a 2-bit address. Address 0 is the low count byte, 1 is the high count byte, 2 is control and 3 is status. Read data is combinational from `addr`.

Top module: `gated_count16`

## Requirements
- R1: After reset the count is 0x0000, the control register reads 0x00, the status register reads 0x00 and `irq` is low.
- R2: A write to address 0 loads only the low count byte and a write to address 1 loads only the high count byte. Each byte reads back at its own address, and the other byte keeps its value.
- R3: Control bit 0 (run) enables counting. With run set, source bit 1 = 0 and prescale 1:1, each clock cycle with `tick` high adds one to the count. With run clear, nothing counts.
- R4: Control bits [3:2] select the prescale ratio: 0 divides by 1, 1 by 2, 2 by 4 and 3 by 8. The count advances once per that many qualified source events.
- R5: With control bit 1 set, the counter counts rising edges of `ext_clk` after a two-flop synchroniser, and `tick` has no effect.
- R6: With gate enable (control bit 4) set, source events only count while the synchronised `gate` equals the polarity bit (control bit 5: 1 = active high, 0 = active low). While the gate is inactive the count holds.
- R7: With gate enable clear, the level of `gate` has no effect on counting.
- R8: An increment from 0xFFFF to 0x0000 sets status bit 0, and `irq` follows status bit 0.
- R9: The overflow flag stays set while counting goes on and while status is written with bit 0 = 0. A status write with bit 0 = 1 clears it.
- R10: A write to either count byte clears the prescaler, so a full prescale period of new events is needed before the next increment.
- R11: A bus write to a count byte in the same cycle as an increment wins, and the written byte takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 low, 1 high, 2 control, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tick | input | 1 | Internal count tick, one pulse per clock |
| ext_clk | input | 1 | Asynchronous external clock |
| gate | input | 1 | Asynchronous gate input |
| irq | output | 1 | Sticky overflow interrupt flag |

## Verification
The hardest state to reach from the ports is a prescaler that holds part of a period at the moment a count byte is written. If the clear on write is missing, the next increment comes early. The stimulus sets the ratio to 1:8 and sends five ticks, so three ticks are left in the period. It then rewrites the low byte and checks that seven further ticks give no increment and the eighth gives one. Gate tests move the gate level first and wait out the synchroniser before any source events, so that each event falls clearly inside or outside the gated window.

// File: rtl/gated_count16.sv
module gated_count16 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic       ext_clk,
  input  logic       gate,
  output logic       irq
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2, A_STS = 2'd3;

  logic [15:0] cnt;
  logic [5:0]  ctl;
  logic        ovf;
  logic [2:0]  pre;
  logic [SYNC_STAGES:0]   ck_sh;
  logic [SYNC_STAGES-1:0] gt_sh;

  logic run, src_ext, gate_en, gate_pol;
  logic [1:0] ps;
  assign run      = ctl[0];
  assign src_ext  = ctl[1];
  assign ps       = ctl[3:2];
  assign gate_en  = ctl[4];
  assign gate_pol = ctl[5];

  logic ck_rise, gate_ok, src_ev, ev, incr, cnt_wr;
  logic [2:0] pmask;

  assign ck_rise = ck_sh[SYNC_STAGES-1] & ~ck_sh[SYNC_STAGES];
  assign gate_ok = ~gate_en | (gt_sh[SYNC_STAGES-1] == gate_pol);
  assign src_ev  = src_ext ? ck_rise : tick;
  assign ev      = run & gate_ok & src_ev;
  assign pmask   = 3'((4'd1 << ps) - 4'd1);
  assign incr    = ev & ((pre | ~pmask) == 3'b111);
  assign cnt_wr  = wr_en & (addr == A_LO || addr == A_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sh <= '0;
      gt_sh <= '0;
    end else begin
      ck_sh <= {ck_sh[SYNC_STAGES-1:0], ext_clk};
      gt_sh <= {gt_sh[SYNC_STAGES-2:0], gate};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pre <= '0;
    else if (cnt_wr) pre <= '0;
    else if (ev)     pre <= pre + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      if (addr == A_LO) cnt[7:0]  <= wdata;
      else              cnt[15:8] <= wdata;
    end else if (incr) begin
      cnt <= cnt + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           ctl <= '0;
    else if (wr_en && addr == A_CTL)      ctl <= wdata[5:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                 ovf <= 1'b0;
    else if (incr && !cnt_wr && &cnt)           ovf <= 1'b1;
    else if (wr_en && addr == A_STS && wdata[0]) ovf <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_LO:    rdata = cnt[7:0];
      A_HI:    rdata = cnt[15:8];
      A_CTL:   rdata = {2'b00, ctl};
      default: rdata = {7'b0, ovf};
    endcase
  end

  assign irq = ovf;
endmodule

// File: rtl/gated_count16_chk.sv
module gated_count16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic [15:0] cnt,
  input logic [2:0]  pre,
  input logic        incr,
  input logic        gate_ok,
  input logic        cnt_wr,
  input logic        irq
);
  // R8
  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !cnt_wr && cnt == 16'hFFFF) |=> (irq && cnt == 16'h0000));

  // R9
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd3 && wdata[0])) |=> irq);

  // R3
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

  // R6
  a_r6_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_ok && !cnt_wr) |=> $stable(cnt));

  // R10
  a_r10_write_clears_pre: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (pre == 3'd0));

  // R11
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (cnt[7:0] == $past(wdata)));
endmodule

bind gated_count16 gated_count16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt), .pre(pre), .incr(incr), .gate_ok(gate_ok), .cnt_wr(cnt_wr),
  .irq(irq)
);

// File: tb/tb_gated_count16.sv
module tb_gated_count16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0, ext_clk = 1'b0, gate = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int total = 0, bad = 0;

  gated_count16 dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .ext_clk(ext_clk), .gate(gate), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk); gate = g;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_cnt();
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d; int v;
    rd_cnt(v); chk("R1 count", v, 0);
    rd(2'd2, d); chk("R1 ctrl", d, 0);
    rd(2'd3, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3);
    rd(2'd0, d); chk("R2 low", d, 8'h5A);
    rd(2'd1, d); chk("R2 high", d, 8'hC3);
    wr(2'd0, 8'h11);
    rd(2'd1, d); chk("R2 high kept", d, 8'hC3);
    rd(2'd0, d); chk("R2 low new", d, 8'h11);
  endtask

  task automatic t_internal();
    int v;
    clr_cnt(); wr(2'd2, 8'h00); ticks(5);
    rd_cnt(v); chk("R3 stopped", v, 0);
    wr(2'd2, 8'h01); ticks(7);
    rd_cnt(v); chk("R3 count ticks", v, 7);
  endtask

  task automatic t_prescale();
    int v;
    wr(2'd2, 8'h05); clr_cnt(); ticks(6);
    rd_cnt(v); chk("R4 div2", v, 3);
    wr(2'd2, 8'h09); clr_cnt(); ticks(8);
    rd_cnt(v); chk("R4 div4", v, 2);
    wr(2'd2, 8'h0D); clr_cnt(); ticks(7);
    rd_cnt(v); chk("R4 div8 partial", v, 0);
    ticks(9);
    rd_cnt(v); chk("R4 div8", v, 2);
  endtask

  task automatic t_pre_clear();
    int v;
    wr(2'd2, 8'h0D); clr_cnt(); ticks(5);
    wr(2'd0, 8'h00); ticks(7);
    rd_cnt(v); chk("R10 prescaler cleared", v, 0);
    ticks(1);
    rd_cnt(v); chk("R10 full period", v, 1);
  endtask

  task automatic t_external();
    int v;
    wr(2'd2, 8'h03); clr_cnt(); pulses(5);
    rd_cnt(v); chk("R5 ext edges", v, 5);
    ticks(4);
    rd_cnt(v); chk("R5 tick ignored", v, 5);
  endtask

  task automatic t_gate();
    int v;
    wr(2'd2, 8'h31); clr_cnt();
    set_gate(1'b0); ticks(4);
    rd_cnt(v); chk("R6 high-active closed", v, 0);
    set_gate(1'b1); ticks(4);
    rd_cnt(v); chk("R6 high-active open", v, 4);
    wr(2'd2, 8'h11); clr_cnt();
    set_gate(1'b1); ticks(3);
    rd_cnt(v); chk("R6 low-active closed", v, 0);
    set_gate(1'b0); ticks(3);
    rd_cnt(v); chk("R6 low-active open", v, 3);
    wr(2'd2, 8'h21); clr_cnt();
    set_gate(1'b0); ticks(2); set_gate(1'b1); ticks(2);
    rd_cnt(v); chk("R7 gate ignored", v, 4);
  endtask

  task automatic t_overflow();
    logic [7:0] d; int v;
    wr(2'd2, 8'h01); wr(2'd1, 8'hFF); wr(2'd0, 8'hFE);
    ticks(1);
    rd(2'd3, d); chk("R8 no flag at FFFF", d, 0);
    ticks(1);
    rd_cnt(v); chk("R8 wrapped", v, 0);
    rd(2'd3, d); chk("R8 flag", d, 1);
    chk("R8 irq", irq, 1);
    wr(2'd3, 8'h00); ticks(3);
    rd(2'd3, d); chk("R9 sticky", d, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, d); chk("R9 cleared", d, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(2'd2, 8'h01); clr_cnt();
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, d); chk("R11 write wins", d, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_bytes(); t_internal(); t_prescale(); t_pre_clear();
    t_external(); t_gate(); t_overflow(); t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule